// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block produces the clock half-periods of a two-wire serial bus master. It counts cycles of a fixed reference clock. Three 32-bit timing words set the lengths. Each word carries two 16-bit fields:

- the length of the SCL high half-period,
- the length of the SCL low half-period,
- the hold time after a START condition,
- the idle gap required after a STOP.

The block also carries two offsets inside the half-periods:

- the cycle in the low half where the byte engine may change SDA,
- the cycle in the high half where it should sample SDA.

The engine raises `runEn` to begin a transfer and keeps it high while more bits remain. The block then walks through five phases: idle, START hold, low, high and bus-free. Each phase appears on the `phase` output.

During the low phase the block drives SCL low. Outside the low phase SCL is released. The high phase counts only cycles in which the SCL input is really high, so a target that holds SCL low stretches the clock. After the final high phase, a new START is refused until the bus-free time has passed.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset `phase` is 0 (idle), `sclOe` is 0 and both strobes are 0.
- R2: `highWord[31:16]` is the high count H and `highWord[15:0]` is the sample offset RX. `lowWord[31:16]` is the low count L and `lowWord[15:0]` is the change offset TX. `gapWord[31:16]` is the bus-free time F and `gapWord[15:0]` is the START hold time S.
- R3: Each low phase (`phase`=2) lasts exactly L+2 cycles with `sclOe`=1. `sclOe` is 0 in every other phase.
- R4: Each high phase (`phase`=3) ends after exactly H+7 cycles in which `sclIn` is 1. Cycles with `sclIn`=0 do not count, and the phase cannot end in such a cycle.
- R5: `txStrobe` pulses exactly once per low phase, in the cycle with index TX counted from 0, and never outside a low phase. TX must be below L+2.
- R6: `rxStrobe` pulses exactly once per high phase, in the cycle in which RX high cycles have already been counted, and never outside a high phase. RX must be below H+7.
- R7: In idle with `runEn`=1, the next cycle enters START hold (`phase`=1). START hold lasts max(S,1) cycles with SCL released and is followed by a low phase.
- R8: At the end of a high phase the block enters a low phase if `runEn` is 1. Otherwise it enters bus-free (`phase`=4).
- R9: Bus-free lasts max(F,1) cycles whatever `runEn` does, then returns to idle. With `runEn` held high, idle lasts one cycle before the next START hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Start request; held high while more bits follow |
| sclIn | input | 1 | Sensed SCL level |
| highWord | input | 32 | High count and sample offset |
| lowWord | input | 32 | Low count and change offset |
| gapWord | input | 32 | Bus-free time and START hold time |
| sclOe | output | 1 | 1 = pull SCL low |
| txStrobe | output | 1 | SDA may change this cycle |
| rxStrobe | output | 1 | Sample SDA this cycle |
| phase | output | 3 | 0 idle, 1 START hold, 2 low, 3 high, 4 bus-free |

## Verification
A fault in the phase counter shows up at the ports within one phase. It appears as a half-period with the wrong length on `sclOe`, or as a strobe at the wrong index, or as a missing or doubled strobe.

A fault in the phase state shows up at the next phase boundary. It appears as the wrong successor on `phase`, or as a bus-free interval that a waiting START cuts short.

Stretch handling only shows while `sclIn` is held low. It therefore shows as a high phase that fails to lengthen by exactly the stretched cycles, or as a sample strobe that shifts by the wrong amount.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_LOW  = 3'd2,
    PH_HIGH = 3'd3,
    PH_FREE = 3'd4
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   clear;
    logic   step;
    phase_e phase;
  } ctrl_s;

  // datapath -> control status
  typedef struct packed {
    logic last;
    logic atTx;
    logic atRx;
  } stat_s;

endpackage

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int HIGH_ADD = 7,
  parameter int LOW_ADD  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_s              ctrl,
  input  logic [2*FIELD_W-1:0] highWord,
  input  logic [2*FIELD_W-1:0] lowWord,
  input  logic [2*FIELD_W-1:0] gapWord,
  output stat_s              stat
);
  localparam int LEN_W = FIELD_W + 1;

  logic [FIELD_W-1:0] highCnt, rxOff, lowCnt, txOff, freeCnt, leadCnt;
  logic [LEN_W-1:0]   phaseLen;
  logic [LEN_W-1:0]   cnt;

  // field split: upper half = length, lower half = offset / hold
  assign highCnt = highWord[2*FIELD_W-1:FIELD_W];
  assign rxOff   = highWord[FIELD_W-1:0];
  assign lowCnt  = lowWord[2*FIELD_W-1:FIELD_W];
  assign txOff   = lowWord[FIELD_W-1:0];
  assign freeCnt = gapWord[2*FIELD_W-1:FIELD_W];
  assign leadCnt = gapWord[FIELD_W-1:0];

  always_comb begin
    case (ctrl.phase)
      PH_LEAD: phaseLen = LEN_W'(leadCnt);
      PH_LOW:  phaseLen = LEN_W'(lowCnt) + LEN_W'(LOW_ADD);
      PH_HIGH: phaseLen = LEN_W'(highCnt) + LEN_W'(HIGH_ADD);
      PH_FREE: phaseLen = LEN_W'(freeCnt);
      default: phaseLen = LEN_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctrl.clear) cnt <= '0;
    else if (ctrl.step)  cnt <= cnt + LEN_W'(1);
  end

  // a zero length behaves as one cycle
  assign stat.last = (cnt + LEN_W'(1)) >= phaseLen;
  assign stat.atTx = cnt == LEN_W'(txOff);
  assign stat.atRx = cnt == LEN_W'(rxOff);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timing_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  runEn,
  input  logic  sclIn,
  input  stat_s stat,
  output ctrl_s ctrl
);
  phase_e curPhase, nxtPhase;
  logic   clr, stp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curPhase <= PH_IDLE;
    else       curPhase <= nxtPhase;
  end

  always_comb begin
    nxtPhase = curPhase;
    clr      = 1'b0;
    stp      = 1'b0;
    case (curPhase)
      PH_IDLE: begin
        if (runEn) begin
          nxtPhase = PH_LEAD;
          clr      = 1'b1;
        end
      end
      PH_LEAD: begin
        stp = 1'b1;
        if (stat.last) begin
          nxtPhase = PH_LOW;
          clr      = 1'b1;
        end
      end
      PH_LOW: begin
        stp = 1'b1;
        if (stat.last) begin
          nxtPhase = PH_HIGH;
          clr      = 1'b1;
        end
      end
      PH_HIGH: begin
        stp = sclIn;  // stretched cycles do not count
        if (stat.last && sclIn) begin
          nxtPhase = runEn ? PH_LOW : PH_FREE;
          clr      = 1'b1;
        end
      end
      PH_FREE: begin
        stp = 1'b1;   // start requests wait here
        if (stat.last) begin
          nxtPhase = PH_IDLE;
          clr      = 1'b1;
        end
      end
      default: begin
        nxtPhase = PH_IDLE;
        clr      = 1'b1;
      end
    endcase
  end

  assign ctrl.clear = clr;
  assign ctrl.step  = stp;
  assign ctrl.phase = curPhase;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int HIGH_ADD = 7,
  parameter int LOW_ADD  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic                 sclIn,
  input  logic [2*FIELD_W-1:0] highWord,
  input  logic [2*FIELD_W-1:0] lowWord,
  input  logic [2*FIELD_W-1:0] gapWord,
  output logic                 sclOe,
  output logic                 txStrobe,
  output logic                 rxStrobe,
  output logic [2:0]           phase
);
  ctrl_s ctrl;
  stat_s stat;

  scl_phase_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .runEn (runEn),
    .sclIn (sclIn),
    .stat  (stat),
    .ctrl  (ctrl)
  );

  scl_phase_counter #(
    .FIELD_W  (FIELD_W),
    .HIGH_ADD (HIGH_ADD),
    .LOW_ADD  (LOW_ADD)
  ) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .highWord (highWord),
    .lowWord  (lowWord),
    .gapWord  (gapWord),
    .stat     (stat)
  );

  assign sclOe    = ctrl.phase == PH_LOW;
  assign txStrobe = (ctrl.phase == PH_LOW) && stat.atTx;
  assign rxStrobe = (ctrl.phase == PH_HIGH) && sclIn && stat.atRx;
  assign phase    = ctrl.phase;

endmodule

// File: rtl/scl_timing_gen_checker.sv
module scl_timing_gen_checker (
  input logic       clk,
  input logic       rstN,
  input logic       runEn,
  input logic       sclIn,
  input logic       txStrobe,
  input logic       rxStrobe,
  input logic [2:0] phase
);
  AST_IDLE_TO_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 && runEn) |=> phase == 3'd1);                          // R7
  AST_LOW_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));                // R3
  AST_HIGH_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd3 && !sclIn) |=> phase == 3'd3);                         // R4
  AST_HIGH_NO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd3 && !runEn) |=> (phase == 3'd3 || phase == 3'd4));      // R8
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd4) |=> (phase == 3'd4 || phase == 3'd0));                // R9
  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> !txStrobe);                                              // R5
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && phase == 3'd3) |=> !rxStrobe);                           // R6
endmodule

bind scl_timing_gen scl_timing_gen_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .runEn    (runEn),
  .sclIn    (sclIn),
  .txStrobe (txStrobe),
  .rxStrobe (rxStrobe),
  .phase    (phase)
);

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic stretch = 1'b0;
  logic sclIn;
  logic [31:0] highWord = '0, lowWord = '0, gapWord = '0;
  logic sclOe, txStrobe, rxStrobe;
  logic [2:0] phase;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sclIn = !sclOe && !stretch;  // open-drain loop with target hold

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rstN(rstN), .runEn(runEn), .sclIn(sclIn),
    .highWord(highWord), .lowWord(lowWord), .gapWord(gapWord),
    .sclOe(sclOe), .txStrobe(txStrobe), .rxStrobe(rxStrobe), .phase(phase)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int atLeast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic burst(input int hi, input int rx, input int lo, input int tx,
                       input int lead, input int free, input int nHigh,
                       input int sGap, input bit restart);
    int prev = 0, runLen = 0, txCnt = 0, txIdx = -1, rxCnt = 0, rxIdx = -1;
    int highs = 0, ph, idx;
    bit oeBad = 0, stray = 0, restarted = 0, fin = 0, freeSeen = 0;
    highWord = {16'(hi), 16'(rx)};   // R2 field placement
    lowWord  = {16'(lo), 16'(tx)};
    gapWord  = {16'(free), 16'(lead)};
    runEn = 1'b1;
    for (int k = 0; k < 20000 && !fin; k++) begin
      @(negedge clk);
      ph = int'(phase);
      idx = (ph == prev) ? runLen : 0;
      stretch = (ph == 3) && (idx < sGap);
      #1;
      if (k == 0) chk(ph, 1, "R7 start hold follows run");
      if (ph != prev) begin
        case (prev)
          1: chk(runLen, atLeast1(lead), "R7 start hold length");
          2: begin
            chk(runLen, lo + 2, "R3 low length (R2 fields)");
            chk(txCnt, 1, "R5 change strobe count");
            chk(txIdx, tx, "R5 change strobe index");
          end
          3: begin
            chk(runLen, sGap + hi + 7, "R4 high length with stretch");
            chk(rxCnt, 1, "R6 sample strobe count");
            chk(rxIdx, sGap + rx, "R6 sample strobe index");
          end
          4: chk(runLen, atLeast1(free), "R9 bus-free length");
          0: if (restarted) chk(runLen, 1, "R9 idle before restart");
          default: ;
        endcase
        if (prev != 0) begin
          chk(int'(oeBad), 0, "R3 scl drive matches phase");
          chk(int'(stray), 0, "R5 R6 strobe outside its phase");
        end
        if (ph == 1 && prev != 0) chk(prev, 0, "R7 start hold entered from idle");
        if (ph == 2 && prev != 1 && prev != 3) chk(prev, 3, "R8 low after high");
        if (ph == 4 && !freeSeen) begin
          chk(highs, nHigh, "R8 high phases before bus-free");
          freeSeen = 1;
        end
        runLen = 0; txCnt = 0; rxCnt = 0; txIdx = -1; rxIdx = -1;
        oeBad = 0; stray = 0;
        if (ph == 3) highs++;
        if (ph == 3 && highs == nHigh) runEn = 1'b0;
        if (ph == 4 && restart && !restarted) begin
          runEn = 1'b1;
          restarted = 1;
        end
        if (ph == 1 && restarted) runEn = 1'b0;
      end
      runLen++;
      if (sclOe != (ph == 2)) oeBad = 1;
      if (txStrobe) begin
        if (ph != 2) stray = 1;
        txCnt++;
        txIdx = runLen - 1;
      end
      if (rxStrobe) begin
        if (ph != 3) stray = 1;
        rxCnt++;
        rxIdx = runLen - 1;
      end
      if (ph == 0 && prev == 0 && !runEn && highs > 0) fin = 1;
      prev = ph;
    end
    stretch = 1'b0;
    if (!fin) chk(0, 1, "R9 burst did not return to idle");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(int'(phase), 0, "R1 reset phase");
    chk(int'(sclOe), 0, "R1 reset scl drive");
    chk(int'(txStrobe) + int'(rxStrobe), 0, "R1 reset strobes");
    rstN = 1'b1;
    @(negedge clk);
    for (int hi = 0; hi < 3; hi++)
      for (int lo = 0; lo < 3; lo++)
        for (int s = 0; s < 2; s++)
          burst(hi, (lo * 3) % (hi + 7), lo, (hi + lo) % (lo + 2),
                lo, hi * 2, 1 + (lo % 3), 2 * s, hi == lo);
    burst(8, 5, 20, 7, 14, 30, 3, 3, 1'b1);
    burst(1, 7, 3, 4, 0, 0, 2, 0, 1'b1);       // last-cycle offsets, zero gaps
    burst(30, 0, 40, 0, 200, 150, 2, 5, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule